// File: doc/BRIEF.md
# RF Carrier Collision Avoidance Controller

This block decides when a near-field device may leave its passive listening role, become the initiator and turn on its own 13.56 MHz carrier. By default the device sits in the target role with its carrier off and its field-level detector running. When the application asks to become initiator, the block moves into a listen phase. It turns the carrier on only after the external-field detector has reported silence for a full, programmable guard time counted in clock ticks. If any external field is seen during that window, the count starts over from zero.

Once the carrier is on, the block sends a one-cycle pulse that starts protocol initialization. It then holds the initiator role until the transaction ends or is aborted. The transfer-rate selection is frozen from the moment the listen phase begins until the block is back in the target role. A rate request made while frozen is discarded and reported with a one-cycle flag. Protocol initialization content and the analog detector itself lie outside this block.

Top module: `rf_cav_ctrl`

## Requirements
- R1: After reset, role_init=0, rf_on=0, det_en=1, init_start=0 and rate_sel equals the parameter RATE_RST (default 0).
- R2: det_en is 1 exactly when rf_on is 0. The detector runs in the target and listen phases and is off while the block's own carrier is on.
- R3: With init_req low the block stays in the target role (role_init=0, rf_on=0) whatever field_det does. With init_req high and abort_req low in the target role, role_init is 1 after the next clock edge and rf_on stays 0.
- R4: In the listen phase rf_on rises after max(guard_ticks,1) consecutive clock edges with field_det low. Counting from the cycle in which init_req is first driven high, rf_on is seen high G+1 edges later (G = max(guard_ticks,1)). A field that never goes quiet keeps rf_on at 0.
- R5: A field_det sample of 1 during the listen phase restarts the quiet count from zero. A single-cycle field sampled on listen edge j (j ≤ G) delays carrier-on to G+1+j edges after the request.
- R6: init_start is high for exactly one cycle, the first cycle in which rf_on is 1.
- R7: txn_end sampled high while the carrier is on returns the block to the target role (rf_on=0, role_init=0, det_en=1) after one edge.
- R8: abort_req sampled high in any phase, or init_req sampled low during the listen phase, returns the block to the target role with the carrier off after one edge.
- R9: In the target role, rate_req_vld=1 loads rate_req into rate_sel after one edge, and rate_blocked stays 0.
- R10: While role_init is 1, a rate_req_vld pulse leaves rate_sel unchanged and raises rate_blocked for exactly one cycle after the edge. The ignored value does not appear after the block returns to the target role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| field_det | input | 1 | External RF field present (from level detector) |
| init_req | input | 1 | Application asks to act as initiator (level) |
| abort_req | input | 1 | Force return to target role |
| txn_end | input | 1 | Current transaction finished |
| guard_ticks | input | GUARD_W | Required quiet time in clock ticks (0 treated as 1) |
| rate_req | input | RATE_W | Requested transfer-rate code |
| rate_req_vld | input | 1 | Rate request strobe |
| rf_on | output | 1 | Own carrier enable |
| role_init | output | 1 | 1 = initiator role, 0 = target role |
| det_en | output | 1 | Field level detector enable |
| init_start | output | 1 | One-cycle pulse to start initialization |
| rate_sel | output | RATE_W | Locked transfer-rate selection |
| rate_blocked | output | 1 | One-cycle flag: rate request refused |

## Verification
A quiet counter that fails to clear or that compares against the wrong limit shows at rf_on. The carrier then rises one or more edges before or after the G+1 edge expected from the request, and a field pulse fails to push the rise back by its own offset. A phase register stuck in listen or active shows at the next edge after abort_req, txn_end or a dropped request, as a role_init or rf_on that stays high. A rate latch that is not frozen shows as a changed rate_sel one edge after a refused request, and the leaked value stays visible once the block is back in the target role.

// File: rtl/rf_cav_pkg.sv
package rf_cav_pkg;
   typedef enum logic [1:0] {
      PH_TARGET = 2'd0,
      PH_LISTEN = 2'd1,
      PH_ACTIVE = 2'd2
   } cav_phase_e;
endpackage

// File: rtl/rf_cav_sync.sv
module rf_cav_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_flops
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else if (STAGES == 1) chain <= d;
            else chain <= {chain[STAGES-2:0], d};
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rf_cav_guard.sv
module rf_cav_guard #(
   parameter int GUARD_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               field,
   input  logic [GUARD_W-1:0] limit,
   output logic               expired
);
   localparam int CW = GUARD_W + 1;

   logic [CW-1:0] quiet_cnt;
   logic [CW-1:0] next_cnt;
   logic [CW-1:0] need;

   assign next_cnt = quiet_cnt + CW'(1);
   assign need     = (limit == '0) ? CW'(1) : {1'b0, limit};
   assign expired  = run && !field && (next_cnt >= need);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) quiet_cnt <= '0;
      else if (!run || field || expired) quiet_cnt <= '0;
      else quiet_cnt <= next_cnt;
   end
endmodule

// File: rtl/rf_cav_rate.sv
module rf_cav_rate #(
   parameter int RATE_W   = 2,
   parameter int RATE_RST = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              locked,
   input  logic              req_vld,
   input  logic [RATE_W-1:0] req_val,
   output logic [RATE_W-1:0] sel,
   output logic              refused
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel     <= RATE_W'(RATE_RST);
         refused <= 1'b0;
      end else begin
         refused <= req_vld && locked;
         if (req_vld && !locked) sel <= req_val;
      end
   end
endmodule

// File: rtl/rf_cav_ctrl.sv
module rf_cav_ctrl
   import rf_cav_pkg::*;
#(
   parameter int GUARD_W    = 8,
   parameter int RATE_W     = 2,
   parameter int RATE_RST   = 0,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               field_det,
   input  logic               init_req,
   input  logic               abort_req,
   input  logic               txn_end,
   input  logic [GUARD_W-1:0] guard_ticks,
   input  logic [RATE_W-1:0]  rate_req,
   input  logic               rate_req_vld,
   output logic               rf_on,
   output logic               role_init,
   output logic               det_en,
   output logic               init_start,
   output logic [RATE_W-1:0]  rate_sel,
   output logic               rate_blocked
);
   localparam int RATE_CODES = 1 << RATE_W;

   if (GUARD_W < 1) begin : g_bad_guard
      $error("GUARD_W must be at least 1");
   end
   if (RATE_W < 1) begin : g_bad_rate
      $error("RATE_W must be at least 1");
   end
   if (RATE_RST < 0 || RATE_RST >= RATE_CODES) begin : g_bad_rst
      $error("RATE_RST outside the rate code range");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   cav_phase_e phase, phase_nx;
   logic       field_s;
   logic       guard_done;
   logic       start_q;

   rf_cav_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (field_det),
      .q     (field_s)
   );

   rf_cav_guard #(.GUARD_W(GUARD_W)) u_guard (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (phase == PH_LISTEN && init_req && !abort_req),
      .field   (field_s),
      .limit   (guard_ticks),
      .expired (guard_done)
   );

   rf_cav_rate #(.RATE_W(RATE_W), .RATE_RST(RATE_RST)) u_rate (
      .clk     (clk),
      .rst_n   (rst_n),
      .locked  (phase != PH_TARGET),
      .req_vld (rate_req_vld),
      .req_val (rate_req),
      .sel     (rate_sel),
      .refused (rate_blocked)
   );

   always_comb begin
      phase_nx = phase;
      unique case (phase)
         PH_TARGET: if (init_req && !abort_req) phase_nx = PH_LISTEN;
         PH_LISTEN: begin
            if (abort_req || !init_req) phase_nx = PH_TARGET;
            else if (guard_done)        phase_nx = PH_ACTIVE;
         end
         PH_ACTIVE: if (abort_req || txn_end) phase_nx = PH_TARGET;
         default:   phase_nx = PH_TARGET;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_TARGET;
         start_q <= 1'b0;
      end else begin
         phase   <= phase_nx;
         start_q <= (phase == PH_LISTEN) && (phase_nx == PH_ACTIVE);
      end
   end

   assign rf_on      = (phase == PH_ACTIVE);
   assign role_init  = (phase != PH_TARGET);
   assign det_en     = (phase != PH_ACTIVE);
   assign init_start = start_q;
endmodule

// File: rtl/rf_cav_ctrl_chk.sv
module rf_cav_ctrl_chk #(
   parameter int GUARD_W = 8,
   parameter int RATE_W  = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               field_det,
   input logic               init_req,
   input logic               abort_req,
   input logic [GUARD_W-1:0] guard_ticks,
   input logic               rf_on,
   input logic               role_init,
   input logic               det_en,
   input logic               init_start,
   input logic [RATE_W-1:0]  rate_sel
);
   logic [31:0] quiet_seen;
   logic [31:0] need;

   assign need = (guard_ticks == '0) ? 32'd1 : 32'(guard_ticks);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) quiet_seen <= '0;
      else if (role_init && !rf_on && !field_det) quiet_seen <= quiet_seen + 32'd1;
      else quiet_seen <= '0;
   end

   // R1
   target_no_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !role_init |-> !rf_on);

   // R2
   det_vs_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
      det_en != rf_on);

   // R4
   guard_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rf_on) |-> quiet_seen >= need);

   // R5
   field_holds_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (role_init && !rf_on && field_det && init_req && !abort_req) |=> !rf_on);

   // R6
   start_with_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_start |-> (rf_on && $rose(rf_on)));

   // R6
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_start |=> !init_start);

   // R8
   abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req |=> (!rf_on && !role_init));

   // R10
   rate_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (role_init && $past(role_init)) |-> $stable(rate_sel));
endmodule

bind rf_cav_ctrl rf_cav_ctrl_chk #(.GUARD_W(GUARD_W), .RATE_W(RATE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .field_det   (field_det),
   .init_req    (init_req),
   .abort_req   (abort_req),
   .guard_ticks (guard_ticks),
   .rf_on       (rf_on),
   .role_init   (role_init),
   .det_en      (det_en),
   .init_start  (init_start),
   .rate_sel    (rate_sel)
);

// File: tb/tb_rf_cav_ctrl.sv
module tb_rf_cav_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int GW = 8;
   localparam int RW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          field_det = 1'b0;
   logic          init_req = 1'b0;
   logic          abort_req = 1'b0;
   logic          txn_end = 1'b0;
   logic [GW-1:0] guard_ticks = '0;
   logic [RW-1:0] rate_req = '0;
   logic          rate_req_vld = 1'b0;
   logic          rf_on, role_init, det_en, init_start, rate_blocked;
   logic [RW-1:0] rate_sel;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rf_cav_ctrl #(.GUARD_W(GW), .RATE_W(RW)) dut (
      .clk(clk), .rst_n(rst_n), .field_det(field_det), .init_req(init_req),
      .abort_req(abort_req), .txn_end(txn_end), .guard_ticks(guard_ticks),
      .rate_req(rate_req), .rate_req_vld(rate_req_vld), .rf_on(rf_on),
      .role_init(role_init), .det_en(det_en), .init_start(init_start),
      .rate_sel(rate_sel), .rate_blocked(rate_blocked)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // Counts edges until rf_on is seen high (limit guards a hang).
   task automatic wait_rf(input int limit, output int n);
      n = 0;
      for (int k = 1; k <= limit; k++) begin
         tick();
         if (rf_on) begin
            n = k;
            break;
         end
      end
   endtask

   task automatic end_txn();
      txn_end = 1'b1;
      tick();
      txn_end = 1'b0;
      init_req = 1'b0;
      check("R7 rf_on after txn_end", rf_on, 0);
      check("R7 role after txn_end", role_init, 0);
      check("R7 det_en after txn_end", det_en, 1);
      tick();
   endtask

   initial begin
      int n;
      tick();
      // R1
      check("R1 rf_on reset", rf_on, 0);
      check("R1 role reset", role_init, 0);
      check("R1 det_en reset", det_en, 1);
      check("R1 init_start reset", init_start, 0);
      check("R1 rate_sel reset", rate_sel, 0);
      rst_n = 1'b1;
      tick();

      // R3: no request, field toggling: stays target
      for (int k = 0; k < 8; k++) begin
         field_det = k[0];
         tick();
         check("R3 idle role", role_init, 0);
      end
      field_det = 1'b0;

      // R4/R6/R2 sweep over guard values, including 0 treated as 1
      for (int g = 0; g <= 6; g++) begin
         int gexp;
         gexp = (g == 0) ? 1 : g;
         guard_ticks = GW'(g);
         init_req = 1'b1;
         tick();
         check("R3 role after request", role_init, 1);
         check("R2 det_en listening", det_en, 1);
         if (gexp == 1) n = 2;
         else wait_rf(40, n);
         if (gexp == 1) begin
            if (!rf_on) wait_rf(40, n);
            else n = 1;
            n = n + 1;
         end else n = n + 1;
         check("R4 edges to carrier", n, gexp + 1);
         check("R6 init_start first cycle", init_start, 1);
         check("R2 det_en carrier on", det_en, 0);
         tick();
         check("R6 init_start drops", init_start, 0);
         end_txn();
      end

      // R5: single-cycle field at listen edge j
      guard_ticks = GW'(4);
      for (int j = 1; j <= 4; j++) begin
         init_req = 1'b1;
         tick();
         for (int k = 1; k < j; k++) tick();
         field_det = 1'b1;
         tick();
         field_det = 1'b0;
         check("R5 held off by field", rf_on, 0);
         wait_rf(40, n);
         check("R5 edges to carrier", n + j + 1, 4 + 1 + j);
         end_txn();
      end

      // R4: continuous field never yields carrier
      field_det = 1'b1;
      init_req = 1'b1;
      for (int k = 0; k < 20; k++) tick();
      check("R4 busy field no carrier", rf_on, 0);
      check("R4 busy field role", role_init, 1);
      field_det = 1'b0;
      init_req = 1'b0;
      tick();
      // R8: dropped request during listen
      check("R8 drop returns target", role_init, 0);
      check("R8 drop carrier off", rf_on, 0);

      // R8: abort during listen and active
      guard_ticks = GW'(5);
      init_req = 1'b1;
      tick(); tick();
      abort_req = 1'b1;
      tick();
      abort_req = 1'b0;
      init_req = 1'b0;
      check("R8 abort listen role", role_init, 0);
      tick();
      init_req = 1'b1;
      tick();
      wait_rf(40, n);
      abort_req = 1'b1;
      tick();
      abort_req = 1'b0;
      init_req = 1'b0;
      check("R8 abort active carrier", rf_on, 0);
      check("R8 abort active role", role_init, 0);
      tick();

      // R9/R10: rate sweep
      for (int r = 0; r < 4; r++) begin
         rate_req = RW'(r);
         rate_req_vld = 1'b1;
         tick();
         rate_req_vld = 1'b0;
         check("R9 rate loaded idle", rate_sel, r);
         check("R9 no block idle", rate_blocked, 0);
      end
      rate_req = 2'd2; rate_req_vld = 1'b1; tick(); rate_req_vld = 1'b0;
      guard_ticks = GW'(3);
      init_req = 1'b1;
      tick();
      rate_req = 2'd1; rate_req_vld = 1'b1; tick(); rate_req_vld = 1'b0;
      check("R10 listen block flag", rate_blocked, 1);
      check("R10 listen rate held", rate_sel, 2);
      wait_rf(40, n);
      rate_req = 2'd3; rate_req_vld = 1'b1; tick(); rate_req_vld = 1'b0;
      check("R10 active block flag", rate_blocked, 1);
      check("R10 active rate held", rate_sel, 2);
      tick();
      check("R10 flag one cycle", rate_blocked, 0);
      end_txn();
      check("R10 no leak after idle", rate_sel, 2);
      rate_req = 2'd1; rate_req_vld = 1'b1; tick(); rate_req_vld = 1'b0;
      check("R9 rate after txn", rate_sel, 1);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule